// File: doc/BRIEF.md
# Dual-Phase ADC Frame Sequencer

This block is the master side of a free-running sampling loop to a successive-approximation converter. The converter has a serial interface with an active-low chip select, a serial clock and a single data line. Each frame begins when chip select falls, which starts a conversion. The controller then drives an unbroken run of serial clocks. The first group of clocks only paces the conversion, and any data seen during them is thrown away. The second group shifts in the result, most significant bit first. After the last clock, chip select goes high and stays high for the acquisition interval. The next frame starts when the programmed period has elapsed.

The sample rate is set by the chip-select period and not by the serial clock rate. A frame period that is too short for the clock setting is raised to the shortest legal frame. Both channel results come out together, marked by a one-cycle strobe. An enable input runs and stops the loop. A frame that has already started always runs to completion.

Top module: `adc_frame_seq`

## Requirements
- R1: While reset is held and after it is released with `enable` low, `cs_n` is 1, `sclk` is 0, `sample_vld` is 0 and `samples` is all zeros.
- R2: A frame starts only on a falling edge of `cs_n`. That edge occurs only when `enable` was high on the clock before it. With `enable` low and no frame in flight, `cs_n` stays high.
- R3: Let h = `half_div`, with 0 treated as 1. Each frame holds exactly 48 serial clock periods. Each half period lasts h system clocks, low half first, and the run starts at the falling edge of `cs_n` with no gaps. `cs_n` is low for 96·h system clocks and rises on the same edge as the last `sclk` fall. `sclk` is low whenever `cs_n` is high.
- R4: The values on `sdi` during the first 16 serial clock periods of a frame have no effect on `samples`.
- R5: During serial periods 17 to 48, `sdi` is sampled on each rising edge of `sclk`, MSB first, to form 32 bits. Bits 31..16 are the channel 0 word and bits 15..0 are the channel 1 word. Each word carries its result in its upper 14 bits, and its lowest two bits are discarded. Channel 0's result appears on `samples[13:0]` and channel 1's result appears on `samples[27:14]`.
- R6: `sample_vld` is high for exactly one cycle, in the first cycle in which `cs_n` is high again after a frame. `samples` holds its value until the next strobe.
- R7: The interval from one falling edge of `cs_n` to the next is `frame_len` system clocks when `frame_len` ≥ 96·h + 4. Otherwise the interval is clamped to 96·h + 4, so chip select is always high for at least 4 clocks between frames.
- R8: `half_div` and `frame_len` are captured when a frame starts. Changing them mid-frame affects only later frames.
- R9: If `enable` drops during a frame, that frame still completes with its strobe, and after that `cs_n` stays high. When `enable` rises again while the loop is idle, the next frame starts on the following clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the sampling loop while high |
| half_div | input | 8 | System clocks per serial clock half period (0 is taken as 1) |
| frame_len | input | 16 | Requested chip-select period in system clocks |
| sdi | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idle low |
| samples | output | 28 | Channel 1 result in bits 27:14, channel 0 result in bits 13:0 |
| sample_vld | output | 1 | One-cycle strobe for a new pair of results |

## Verification
The bound checker watches the port-level framing on every cycle:
- `sclk` stays idle low outside a frame.
- Every frame contains exactly 48 rising edges of `sclk`.
- The strobe lines up with the rise of chip select in both directions.
- No frame starts without enable.
- Chip select stays high for at least the minimum time between frames.

Several behaviours can only be shown by the bench's directed scenarios against a behavioural converter model:
- the captured bit values and their channel placement;
- whether conversion-phase data is ignored;
- the exact period and half-period lengths, including the clamp;
- the frame-start capture of the settings;
- the completion of a frame after enable is dropped.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_ACQ  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/adc_sclk_gen.sv
// Serial clock generator: runs a fixed number of half periods per frame,
// flags the rising edges that fall in the readout phase and the final fall.
module adc_sclk_gen #(
  parameter int DIV_W     = 8,
  parameter int CONV_CLKS = 16,
  parameter int READ_CLKS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] half_len,
  output logic             sclk,
  output logic             cap_tick,
  output logic             done_tick
);

  localparam int HALVES = 2 * (CONV_CLKS + READ_CLKS);
  localparam int EDGE_W = $clog2(HALVES);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(HALVES - 1);
  localparam logic [EDGE_W-1:0] FIRST_CAP = EDGE_W'(2 * CONV_CLKS);

  logic [DIV_W-1:0]  hcnt_q, hcnt_d;
  logic [EDGE_W-1:0] edge_q, edge_d;
  logic              sclk_q, sclk_d;
  logic              tick;

  always_comb begin
    tick   = run && (hcnt_q == (half_len - DIV_W'(1)));
    hcnt_d = hcnt_q;
    edge_d = edge_q;
    sclk_d = sclk_q;
    if (start) begin
      hcnt_d = '0;
      edge_d = '0;
      sclk_d = 1'b0;
    end else if (tick) begin
      hcnt_d = '0;
      sclk_d = ~sclk_q;
      edge_d = edge_q + EDGE_W'(1);
    end else if (run) begin
      hcnt_d = hcnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      edge_q <= '0;
      sclk_q <= 1'b0;
    end else begin
      hcnt_q <= hcnt_d;
      edge_q <= edge_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk      = sclk_q;
  assign cap_tick  = tick && !sclk_q && (edge_q >= FIRST_CAP);
  assign done_tick = tick && (edge_q == LAST_EDGE);

endmodule

// File: rtl/adc_rx_capture.sv
// Readout shift register and per-channel result extraction.
module adc_rx_capture #(
  parameter int READ_CLKS = 32,
  parameter int WORD_W    = 16,
  parameter int RES_W     = 14
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     cap,
  input  logic                                     load,
  input  logic                                     sdi,
  output logic [(READ_CLKS/WORD_W)*RES_W-1:0]      samples,
  output logic                                     vld
);

  localparam int NUM_CH = READ_CLKS / WORD_W;
  localparam int OUT_W  = NUM_CH * RES_W;

  logic [READ_CLKS-1:0] shift_q, shift_d;
  logic [OUT_W-1:0]     res_w;
  logic [OUT_W-1:0]     samp_q, samp_d;
  logic                 vld_q, vld_d;

  // Channel ch is the ch-th word shifted in; result sits at its top.
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign res_w[ch*RES_W +: RES_W] = shift_q[READ_CLKS-1-ch*WORD_W -: RES_W];
  end

  always_comb begin
    shift_d = cap  ? {shift_q[READ_CLKS-2:0], sdi} : shift_q;
    samp_d  = load ? res_w : samp_q;
    vld_d   = load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      samp_q  <= '0;
      vld_q   <= 1'b0;
    end else begin
      shift_q <= shift_d;
      samp_q  <= samp_d;
      vld_q   <= vld_d;
    end
  end

  assign samples = samp_q;
  assign vld     = vld_q;

endmodule

// File: rtl/adc_frame_ctrl.sv
// Frame sequencer: owns chip select, the frame period counter and the
// settings captured at each frame start.
module adc_frame_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int PER_W     = 16,
  parameter int CONV_CLKS = 16,
  parameter int READ_CLKS = 32,
  parameter int CS_MIN    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] half_div,
  input  logic [PER_W-1:0] frame_len,
  input  logic             done_tick,
  output logic             cs_n,
  output logic             go,
  output logic             run,
  output logic [DIV_W-1:0] half_len
);

  localparam int HALVES = 2 * (CONV_CLKS + READ_CLKS);
  localparam int CNT_W  = PER_W + 1;

  seq_state_e       state_q, state_d;
  logic             cs_q, cs_d;
  logic [CNT_W-1:0] fcnt_q, fcnt_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic [DIV_W-1:0] half_q, half_d;
  logic [DIV_W-1:0] half_in;
  logic [CNT_W-1:0] min_len, req_len;
  logic             period_end;

  always_comb begin
    half_in    = (half_div == '0) ? DIV_W'(1) : half_div;
    min_len    = CNT_W'(HALVES) * CNT_W'(half_in) + CNT_W'(CS_MIN);
    req_len    = {1'b0, frame_len};
    period_end = (fcnt_q == (per_q - CNT_W'(1)));
    go         = enable && ((state_q == ST_IDLE) ||
                            ((state_q == ST_ACQ) && period_end));
  end

  always_comb begin
    state_d = state_q;
    cs_d    = cs_q;
    fcnt_d  = fcnt_q;
    per_d   = per_q;
    half_d  = half_q;
    if (go) begin
      state_d = ST_XFER;
      cs_d    = 1'b0;
      fcnt_d  = '0;
      half_d  = half_in;
      per_d   = (req_len < min_len) ? min_len : req_len;
    end else begin
      if (state_q != ST_IDLE) begin
        fcnt_d = fcnt_q + CNT_W'(1);
      end
      unique case (state_q)
        ST_XFER: begin
          if (done_tick) begin
            state_d = ST_ACQ;
            cs_d    = 1'b1;
          end
        end
        ST_ACQ: begin
          if (period_end) begin
            state_d = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_q    <= 1'b1;
      fcnt_q  <= '0;
      per_q   <= '0;
      half_q  <= DIV_W'(1);
    end else begin
      state_q <= state_d;
      cs_q    <= cs_d;
      fcnt_q  <= fcnt_d;
      per_q   <= per_d;
      half_q  <= half_d;
    end
  end

  assign cs_n     = cs_q;
  assign run      = (state_q == ST_XFER);
  assign half_len = half_q;

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq #(
  parameter int DIV_W     = 8,
  parameter int PER_W     = 16,
  parameter int CONV_CLKS = 16,
  parameter int READ_CLKS = 32,
  parameter int WORD_W    = 16,
  parameter int RES_W     = 14,
  parameter int CS_MIN    = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                enable,
  input  logic [DIV_W-1:0]                    half_div,
  input  logic [PER_W-1:0]                    frame_len,
  input  logic                                sdi,
  output logic                                cs_n,
  output logic                                sclk,
  output logic [(READ_CLKS/WORD_W)*RES_W-1:0] samples,
  output logic                                sample_vld
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic             go, run, cap_tick, done_tick;
  logic [DIV_W-1:0] half_len;

  adc_frame_ctrl #(
    .DIV_W    (DIV_W),
    .PER_W    (PER_W),
    .CONV_CLKS(CONV_CLKS),
    .READ_CLKS(READ_CLKS),
    .CS_MIN   (CS_MIN)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .enable   (enable),
    .half_div (half_div),
    .frame_len(frame_len),
    .done_tick(done_tick),
    .cs_n     (cs_n),
    .go       (go),
    .run      (run),
    .half_len (half_len)
  );

  adc_sclk_gen #(
    .DIV_W    (DIV_W),
    .CONV_CLKS(CONV_CLKS),
    .READ_CLKS(READ_CLKS)
  ) u_sclk (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (go),
    .run      (run),
    .half_len (half_len),
    .sclk     (sclk),
    .cap_tick (cap_tick),
    .done_tick(done_tick)
  );

  adc_rx_capture #(
    .READ_CLKS(READ_CLKS),
    .WORD_W   (WORD_W),
    .RES_W    (RES_W)
  ) u_rx (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cap    (cap_tick),
    .load   (done_tick),
    .sdi    (sdi),
    .samples(samples),
    .vld    (sample_vld)
  );

endmodule

// File: rtl/adc_frame_seq_chk.sv
module adc_frame_seq_chk #(
  parameter int CONV_CLKS = 16,
  parameter int READ_CLKS = 32,
  parameter int CS_MIN    = 4
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic cs_n,
  input logic sclk,
  input logic sample_vld
);

  localparam int PERIODS = CONV_CLKS + READ_CLKS;

  logic       cs_p, sclk_p, seen_rise;
  logic [7:0] rise_cnt;
  logic [7:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p      <= 1'b1;
      sclk_p    <= 1'b0;
      seen_rise <= 1'b0;
      rise_cnt  <= '0;
      hi_cnt    <= '0;
    end else begin
      cs_p   <= cs_n;
      sclk_p <= sclk;
      if (cs_n && !cs_p) seen_rise <= 1'b1;
      if (cs_p && !cs_n) rise_cnt <= '0;
      else if (sclk && !sclk_p) rise_cnt <= rise_cnt + 8'd1;
      if (!cs_n) hi_cnt <= '0;
      else if (hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 8'd1;
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R3
  AST_SCLK_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk) |-> !$past(cs_n)); // R3
  AST_RISES_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (rise_cnt == 8'(PERIODS))); // R3
  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(enable)); // R2
  AST_VLD_ON_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |-> $rose(cs_n)); // R6
  AST_CS_RISE_GIVES_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> sample_vld); // R6
  AST_CS_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && seen_rise) |-> (hi_cnt >= 8'(CS_MIN))); // R7

endmodule

bind adc_frame_seq adc_frame_seq_chk #(
  .CONV_CLKS(CONV_CLKS),
  .READ_CLKS(READ_CLKS),
  .CS_MIN   (CS_MIN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .cs_n      (cs_n),
  .sclk      (sclk),
  .sample_vld(sample_vld)
);

// File: tb/adc_frame_seq_tb.sv
`timescale 1ns/1ps
module adc_frame_seq_tb;

  localparam int DIV_W = 8;
  localparam int PER_W = 16;
  localparam int RES_W = 14;

  logic             clk;
  logic             rst_n;
  logic             enable;
  logic [DIV_W-1:0] half_div;
  logic [PER_W-1:0] frame_len;
  logic             sdi;
  logic             cs_n, sclk, sample_vld;
  logic [2*RES_W-1:0] samples;

  int n_tests = 0;
  int n_fail  = 0;

  adc_frame_seq u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .half_div(half_div),
    .frame_len(frame_len), .sdi(sdi), .cs_n(cs_n), .sclk(sclk),
    .samples(samples), .sample_vld(sample_vld)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural converter: bit for period k is launched at the fall ending
  // period k-1; conversion periods and pad bits carry junk_val.
  int          fidx = 0;
  int          frame_no = 0;
  logic        junk_val = 1'b1;
  logic [31:0] cur_word = '0;
  logic [RES_W-1:0] exp_a [64];
  logic [RES_W-1:0] exp_b [64];

  always @(negedge cs_n) begin
    logic [RES_W-1:0] a, b;
    a = RES_W'(frame_no * 1031 + 19);
    b = ~a ^ RES_W'(frame_no * 8 + 5);
    exp_a[frame_no % 64] = a;
    exp_b[frame_no % 64] = b;
    cur_word = {a, junk_val, junk_val, b, junk_val, junk_val};
    fidx = 0;
    frame_no++;
  end

  always @(negedge sclk) if (!cs_n) fidx++;

  always_comb begin
    if (fidx >= 16 && fidx < 48) sdi = cur_word[47 - fidx];
    else                         sdi = junk_val;
  end

  // Port monitor, sampled between clock edges.
  longint cyc = 0, last_fall = 0, meas_period = 0;
  int low_cnt = 0, meas_low = 0, hi_run = 0, meas_hi = 0;
  int sclk_rises = 0, meas_rises = 0, vld_cnt = 0, fall_cnt = 0;
  logic cs_prev = 1'b1, sclk_prev = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n === 1'b1) begin
      if (cs_prev && !cs_n) begin
        if (fall_cnt > 0) meas_period = cyc - last_fall;
        last_fall = cyc;
        fall_cnt++;
        low_cnt = 0;
        sclk_rises = 0;
      end
      if (!cs_n) low_cnt++;
      if (!cs_prev && cs_n) begin
        meas_low   = low_cnt;
        meas_rises = sclk_rises;
      end
      if (sclk && !sclk_prev) sclk_rises++;
      if (sclk) hi_run++;
      else if (sclk_prev) begin
        meas_hi = hi_run;
        hi_run  = 0;
      end
      if (sample_vld) begin
        check("R5", "channel 0 result", samples[RES_W-1:0], exp_a[vld_cnt % 64]);
        check("R5", "channel 1 result", samples[2*RES_W-1:RES_W], exp_b[vld_cnt % 64]);
        check("R6", "strobe on cs rise", {cs_prev, cs_n}, 2'b01);
        vld_cnt++;
      end
      cs_prev   = cs_n;
      sclk_prev = sclk;
    end
  end

  task automatic wait_vld(input int n);
    int tgt = vld_cnt + n;
    while (vld_cnt < tgt) @(negedge clk);
    #1;
  endtask

  task automatic wait_fall();
    int tgt = fall_cnt + 1;
    while (fall_cnt < tgt) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    enable = 1'b0; half_div = 8'd1; frame_len = 16'd200; rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R1", "cs_n in reset", cs_n, 1);
    check("R1", "sclk in reset", sclk, 0);
    rst_n = 1'b1;
    repeat (50) @(negedge clk);
    #1;
    check("R1", "vld after reset", sample_vld, 0);
    check("R1", "samples after reset", samples, 0);
    check("R2", "no frame while disabled", fall_cnt, 0);
    check("R2", "cs_n high while disabled", cs_n, 1);
  endtask

  task automatic t_basic();
    half_div = 8'd1; frame_len = 16'd200; junk_val = 1'b1; enable = 1'b1;
    wait_vld(4);
    check("R7", "period h=1", meas_period, 200);
    check("R3", "cs low h=1", meas_low, 96);
    check("R3", "sclk rises", meas_rises, 48);
    check("R3", "sclk high width h=1", meas_hi, 1);
  endtask

  task automatic t_div();
    half_div = 8'd3; frame_len = 16'd400; junk_val = 1'b0;
    wait_vld(3);
    check("R7", "period h=3", meas_period, 400);
    check("R3", "cs low h=3", meas_low, 288);
    check("R3", "sclk high width h=3", meas_hi, 3);
    check("R4", "rises h=3 (conv data junk)", meas_rises, 48);
  endtask

  task automatic t_clamp();
    half_div = 8'd2; frame_len = 16'd10; junk_val = 1'b1;
    wait_vld(3);
    check("R7", "clamped period", meas_period, 196);
    check("R7", "min cs high", meas_period - meas_low, 4);
  endtask

  task automatic t_half0();
    half_div = 8'd0; frame_len = 16'd0;
    wait_vld(3);
    check("R3", "half 0 as 1 low", meas_low, 96);
    check("R7", "half 0 clamp", meas_period, 100);
  endtask

  task automatic t_latch();
    half_div = 8'd1; frame_len = 16'd150;
    wait_vld(3);
    wait_fall();
    half_div = 8'd4; frame_len = 16'd800;
    wait_vld(1);
    check("R8", "mid-frame change ignored", meas_low, 96);
    wait_fall();
    check("R8", "old period kept", meas_period, 150);
    wait_vld(3);
    check("R8", "new low length", meas_low, 384);
    check("R8", "new period", meas_period, 800);
  endtask

  task automatic t_stop();
    int v0, f0;
    half_div = 8'd2; frame_len = 16'd300;
    wait_vld(2);
    wait_fall();
    repeat (20) @(negedge clk);
    #1;
    v0 = vld_cnt; f0 = fall_cnt;
    enable = 1'b0;
    repeat (600) @(negedge clk);
    #1;
    check("R9", "frame finished", vld_cnt, v0 + 1);
    check("R9", "no new frame", fall_cnt, f0);
    check("R9", "cs_n parked high", cs_n, 1);
    enable = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check("R9", "prompt restart", fall_cnt, f0 + 1);
    wait_vld(1);
    check("R9", "restart frame low", meas_low, 192);
  endtask

  initial begin
    #(5.0 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_div();
    t_clamp();
    t_half0();
    t_latch();
    t_stop();
    enable = 1'b0;
    repeat (10) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule